// File: doc/BRIEF.md
# Dual-Core Lockstep Bus Comparator

This block watches the output buses of two identical processor cores that execute the same instruction stream in lockstep. On every cycle in which at least one core drives a valid bus strobe, it compares the two cores' address, write data, control strobes and byte enables. Any disagreement is a detected fault.

A detected fault sets a sticky flag and records which bus group differed in a sticky cause vector. It also raises one interrupt line to each core, and both lines rise in the same cycle. Software reads the flag, the cause and a saturating mismatch count through a small register port, and clears the fault by writing a clear bit. For test, a fault-injection command flips one chosen bit of core B's write data, as the comparator sees it, for exactly one write cycle.

Top module: `lockstep_cmp`

## Requirements
- R1: After reset the status register reads 0, the mismatch count reads 0, and irqA and irqB are low.
- R2: On a cycle where both cores are valid and their addresses differ, the flag (status bit 0) and the address cause bit (status bit 1) read 1 from the next cycle. irqA and irqB rise together in that same cycle.
- R3: On a cycle where neither core asserts its valid strobe, differences on any bus are ignored, and the flag, cause, count and interrupts do not change.
- R4: Write data is compared only on cycles where a valid core signals a write. A difference there sets cause bit 2 (status bit 2). Differing write data on read-only cycles is ignored.
- R5: A difference in the valid strobes or in the write strobes sets the control cause bit (status bit 3).
- R6: A difference in the byte enables on a valid cycle sets the byte-enable cause bit (status bit 4).
- R7: The flag, the cause bits and the interrupts stay set after the buses agree again. Cause bits from later mismatches are ORed into the earlier ones.
- R8: Writing register select 0 with data bit 0 = 1 clears the flag and all cause bits, and both interrupts are low from the next cycle. A write with data bit 0 = 0 changes nothing.
- R9: When a mismatch and a clear occur in the same cycle, the flag stays set and the cause vector holds only the new mismatch's bits.
- R10: Register select 1 reads a count that rises by one on each cycle with a detected mismatch. The count saturates at its maximum value and is not reset by the clear.
- R11: A one-cycle pulse on injArm captures injBit. The next cycle in which core B makes a valid write has that bit of B's write data inverted before the comparison. Only that one write is affected, and read cycles in between do not use up the injection.
- R12: The injected inversion lands on exactly the selected bit. An existing difference at that bit position is cancelled and reports no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aValid | input | 1 | Core A bus strobe |
| aWrite | input | 1 | Core A write (1) or read (0) |
| aAddr | input | ADDR_W | Core A address |
| aWdata | input | DATA_W | Core A write data |
| aBe | input | DATA_W/8 | Core A byte enables |
| bValid | input | 1 | Core B bus strobe |
| bWrite | input | 1 | Core B write (1) or read (0) |
| bAddr | input | ADDR_W | Core B address |
| bWdata | input | DATA_W | Core B write data |
| bBe | input | DATA_W/8 | Core B byte enables |
| injArm | input | 1 | Arms a single-bit fault injection |
| injBit | input | clog2(DATA_W) | Bit of B's write data to invert |
| regSel | input | SEL_W | Register select: 0 status/clear, 1 count |
| regWr | input | 1 | Register write strobe |
| regWdata | input | REG_W | Register write data (bit 0 = clear) |
| regRdata | output | REG_W | Register read data for regSel |
| irqA | output | 1 | Fault interrupt to core A |
| irqB | output | 1 | Fault interrupt to core B |

## Verification
The bench builds the block with an 8-bit address, 16-bit write data (two byte lanes) and a 4-bit count. This keeps the mismatch count small enough that a run of twenty faults reaches saturation. It also lets the bench sweep every injection bit position and every address bit and byte lane. The bench cancels a deliberate write-data difference at each of the sixteen bit positions, which shows that the injection lands on exactly the selected bit.

// File: rtl/lockstep_pkg.sv
`timescale 1ns/1ps
package lockstep_pkg;
  // cause vector bit order; status register places it above the flag bit
  localparam int unsigned GRP_N     = 4;
  localparam int unsigned GRP_ADDR  = 0;
  localparam int unsigned GRP_WDATA = 1;
  localparam int unsigned GRP_CTRL  = 2;
  localparam int unsigned GRP_BE    = 3;

  // register select codes
  localparam int unsigned SEL_STATUS = 0;
  localparam int unsigned SEL_COUNT  = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSticky;
    logic armInj;
  } dpCmd_t;
endpackage

// File: rtl/lockstep_datapath.sv
`timescale 1ns/1ps
module lockstep_datapath
  import lockstep_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [IDX_W-1:0]  injIdx,
  input  logic              aValid,
  input  logic              aWrite,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic [BE_W-1:0]   aBe,
  input  logic              bValid,
  input  logic              bWrite,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic [BE_W-1:0]   bBe,
  output logic [GRP_N-1:0]  diffNow,
  output logic [GRP_N-1:0]  cause,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              injPending;
  logic [IDX_W-1:0]  injSel;
  logic              injFire;
  logic [DATA_W-1:0] injMask;
  logic [DATA_W-1:0] bWdataSeen;
  logic              busActive;
  logic              wrActive;

  // injection consumes itself on the first valid write of core B
  assign injFire = injPending && bValid && bWrite;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign injMask[i] = injFire && (injSel == IDX_W'(i));
  end

  assign bWdataSeen = bWdata ^ injMask;
  assign busActive  = aValid || bValid;
  assign wrActive   = (aValid && aWrite) || (bValid && bWrite);

  always_comb begin
    diffNow            = '0;
    diffNow[GRP_ADDR]  = busActive && (aAddr != bAddr);
    diffNow[GRP_WDATA] = wrActive && (aWdata != bWdataSeen);
    diffNow[GRP_CTRL]  = busActive && ((aValid != bValid) || (aWrite != bWrite));
    diffNow[GRP_BE]    = busActive && (aBe != bBe);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      injPending <= 1'b0;
      injSel     <= '0;
      cause      <= '0;
      count      <= '0;
    end else begin
      if (cmd.armInj) begin
        injPending <= 1'b1;
        injSel     <= injIdx;
      end else if (injFire) begin
        injPending <= 1'b0;
      end
      // a new mismatch wins over a clear in the same cycle
      cause <= (cmd.clrSticky ? '0 : cause) | diffNow;
      if ((|diffNow) && (count != CNT_MAX)) begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockstep_ctrl.sv
`timescale 1ns/1ps
module lockstep_ctrl
  import lockstep_pkg::*;
#(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned REG_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             injArm,
  input  logic [GRP_N-1:0] diffNow,
  input  logic [GRP_N-1:0] cause,
  input  logic [CNT_W-1:0] count,
  output dpCmd_t           cmd,
  output logic [REG_W-1:0] regRdata,
  output logic             irqA,
  output logic             irqB
);
  localparam int unsigned NCORE = 2;

  logic             clrHit;
  logic             flag;
  logic             flagNext;
  logic [NCORE-1:0] irqQ;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata[REG_W-1:1];
  assign clrHit = regWr && (regSel == SEL_W'(SEL_STATUS)) && regWdata[0];

  always_comb begin
    cmd           = '0;
    cmd.clrSticky = clrHit;
    cmd.armInj    = injArm;
  end

  assign flagNext = (flag && !clrHit) || (|diffNow);

  always_ff @(posedge clk) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= flagNext;
  end

  // one interrupt lane per core, loaded from the same next value
  for (genvar c = 0; c < NCORE; c++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN) irqQ[c] <= 1'b0;
      else       irqQ[c] <= flagNext;
    end
  end

  assign irqA = irqQ[0];
  assign irqB = irqQ[1];

  always_comb begin
    regRdata = '0;
    if (regSel == SEL_W'(SEL_STATUS)) begin
      regRdata = REG_W'({cause, flag});
    end else if (regSel == SEL_W'(SEL_COUNT)) begin
      regRdata = REG_W'(count);
    end
  end
endmodule

// File: rtl/lockstep_cmp.sv
`timescale 1ns/1ps
module lockstep_cmp
  import lockstep_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  input  logic              aWrite,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic [BE_W-1:0]   aBe,
  input  logic              bValid,
  input  logic              bWrite,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic [BE_W-1:0]   bBe,
  input  logic              injArm,
  input  logic [IDX_W-1:0]  injBit,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irqA,
  output logic              irqB
);
  dpCmd_t           cmd;
  logic [GRP_N-1:0] diffNow;
  logic [GRP_N-1:0] cause;
  logic [CNT_W-1:0] mismatchCnt;

  lockstep_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .injIdx(injBit),
    .aValid(aValid), .aWrite(aWrite), .aAddr(aAddr), .aWdata(aWdata), .aBe(aBe),
    .bValid(bValid), .bWrite(bWrite), .bAddr(bAddr), .bWdata(bWdata), .bBe(bBe),
    .diffNow(diffNow), .cause(cause), .count(mismatchCnt)
  );

  lockstep_ctrl #(
    .SEL_W(SEL_W), .REG_W(REG_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .injArm(injArm), .diffNow(diffNow), .cause(cause), .count(mismatchCnt),
    .cmd(cmd), .regRdata(regRdata), .irqA(irqA), .irqB(irqB)
  );
endmodule

// File: rtl/lockstep_cmp_chk.sv
`timescale 1ns/1ps
module lockstep_cmp_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             aValid,
  input logic             bValid,
  input logic             clrReq,
  input logic             irqA,
  input logic             irqB,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_irq_pair: assert property (@(posedge clk) disable iff (!rstN)
    irqA == irqB);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!aValid && !bValid && !irqA) |=> !irqA);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqA && !clrReq) |=> irqA);

  a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !aValid && !bValid) |=> (!irqA && !irqB));

  a_r10_cnt_sat: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  a_r10_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cnt == $past(cnt)) || ({1'b0, cnt} == ({1'b0, $past(cnt)} + 1'b1))));
endmodule

bind lockstep_cmp lockstep_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .aValid(aValid), .bValid(bValid),
  .clrReq(regWr && (regSel == '0) && regWdata[0]),
  .irqA(irqA), .irqB(irqB), .cnt(mismatchCnt)
);

// File: tb/lockstep_cmp_test.sv
`timescale 1ns/1ps
module lockstep_cmp_test;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aValid, aWrite, bValid, bWrite;
  logic [ADDR_W-1:0] aAddr, bAddr;
  logic [DATA_W-1:0] aWdata, bWdata;
  logic [BE_W-1:0] aBe, bBe;
  logic injArm;
  logic [IDX_W-1:0] injBit;
  logic [SEL_W-1:0] regSel;
  logic regWr;
  logic [REG_W-1:0] regWdata, regRdata;
  logic irqA, irqB;

  int nChecks = 0;
  int nErrors = 0;
  int expCnt = 0;
  logic [REG_W-1:0] rv;

  always #10 clk = ~clk;

  lockstep_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                 .REG_W(REG_W), .SEL_W(SEL_W)) uut (
    .clk(clk), .rstN(rstN),
    .aValid(aValid), .aWrite(aWrite), .aAddr(aAddr), .aWdata(aWdata), .aBe(aBe),
    .bValid(bValid), .bWrite(bWrite), .bAddr(bAddr), .bWdata(bWdata), .bBe(bBe),
    .injArm(injArm), .injBit(injBit), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .irqA(irqA), .irqB(irqB)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  task automatic setIdle();
    aValid = 0; aWrite = 0; aAddr = '0; aWdata = '0; aBe = '0;
    bValid = 0; bWrite = 0; bAddr = '0; bWdata = '0; bBe = '0;
    injArm = 0; injBit = '0; regSel = '0; regWr = 0; regWdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int sel, output logic [REG_W-1:0] v);
    regSel = SEL_W'(sel);
    #1;
    v = regRdata;
  endtask

  task automatic bothBus(input logic wr, input logic [ADDR_W-1:0] ad,
                         input logic [DATA_W-1:0] wd, input logic [BE_W-1:0] be);
    aValid = 1; bValid = 1; aWrite = wr; bWrite = wr;
    aAddr = ad; bAddr = ad; aWdata = wd; bWdata = wd; aBe = be; bBe = be;
  endtask

  task automatic noteMis();
    if (expCnt < CNT_MAX) expCnt++;
  endtask

  task automatic clearFault();
    setIdle();
    regWr = 1; regSel = '0; regWdata = 16'h0001;
    step();
    regWr = 0;
  endtask

  function automatic int stat(input int grpMask);
    return 1 | (grpMask << 1);
  endfunction

  initial begin
    #(20 * 150000);
    nErrors++; nChecks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    setIdle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    rd(0, rv); check("R1 status", int'(rv), 0);
    rd(1, rv); check("R1 count", int'(rv), 0);
    check("R1 irqA", int'(irqA), 0);
    check("R1 irqB", int'(irqB), 0);

    // R3: idle cycles with differing buses
    aAddr = 8'h12; bAddr = 8'h34; aWdata = 16'h1; bWdata = 16'h2; aBe = 2'b01; bBe = 2'b10;
    aWrite = 1;
    repeat (5) step();
    rd(0, rv); check("R3 idle status", int'(rv), 0);
    rd(1, rv); check("R3 idle count", int'(rv), 0);
    check("R3 idle irq", int'(irqA), 0);

    // R4: differing write data on read cycles ignored
    setIdle(); bothBus(0, 8'h40, 16'h0000, 2'b11);
    aWdata = 16'hAAAA; bWdata = 16'h5555;
    step();
    rd(0, rv); check("R4 read-cycle wdata ignored", int'(rv), 0);
    setIdle(); bothBus(1, 8'h40, 16'hBEEF, 2'b11);
    step();
    rd(0, rv); check("R4 equal write", int'(rv), 0);
    setIdle(); bothBus(1, 8'h40, 16'hBEEF, 2'b11); bWdata = 16'hBEEE;
    step(); noteMis();
    rd(0, rv); check("R4 write mismatch", int'(rv), stat(2));
    clearFault();

    // R10: count increments once
    rd(1, rv); check("R10 first count", int'(rv), 1);

    // R2: address sweep
    for (int i = 0; i < ADDR_W; i++) begin
      setIdle(); bothBus(0, 8'h00, 16'h0, 2'b11); aAddr = ADDR_W'(1 << i);
      step(); noteMis();
      setIdle();
      rd(0, rv); check($sformatf("R2 addr bit %0d status", i), int'(rv), stat(1));
      check("R2 irqA", int'(irqA), 1);
      check("R2 irqB", int'(irqB), 1);
      clearFault();
      rd(0, rv); check("R8 cleared status", int'(rv), 0);
      check("R8 irq low", int'(irqA | irqB), 0);
    end

    // R6: byte-enable lanes
    for (int i = 0; i < BE_W; i++) begin
      setIdle(); bothBus(0, 8'h10, 16'h0, 2'b11); bBe = BE_W'(2'b11 ^ (1 << i));
      step(); noteMis();
      rd(0, rv); check($sformatf("R6 lane %0d", i), int'(rv), stat(8));
      clearFault();
    end

    // R5: valid and write strobe differences
    setIdle(); bothBus(0, 8'h22, 16'h0, 2'b11); bValid = 0;
    step(); noteMis();
    rd(0, rv); check("R5 valid differs", int'(rv), stat(4));
    clearFault();
    setIdle(); bothBus(1, 8'h22, 16'h1234, 2'b11); bWrite = 0;
    step(); noteMis();
    rd(0, rv); check("R5 write differs", int'(rv), stat(4));
    clearFault();

    // R7: sticky and accumulating
    setIdle(); bothBus(0, 8'h01, 16'h0, 2'b11); bAddr = 8'h02;
    step(); noteMis();
    setIdle(); bothBus(0, 8'h01, 16'h0, 2'b11); bBe = 2'b01;
    step(); noteMis();
    setIdle(); bothBus(0, 8'h01, 16'h0, 2'b11);
    repeat (3) step();
    rd(0, rv); check("R7 accumulated", int'(rv), stat(1 | 8));
    check("R7 irq held", int'(irqA & irqB), 1);

    // R8: write without bit 0 does nothing
    setIdle(); regWr = 1; regSel = '0; regWdata = 16'hFFFE;
    step(); regWr = 0;
    rd(0, rv); check("R8 no-clear write", int'(rv), stat(1 | 8));
    clearFault();
    rd(0, rv); check("R8 clear", int'(rv), 0);
    check("R8 irq low after clear", int'(irqA | irqB), 0);

    // R9: clear collides with new mismatch
    setIdle(); bothBus(0, 8'h05, 16'h0, 2'b11); bAddr = 8'h06;
    step(); noteMis();
    setIdle(); bothBus(0, 8'h05, 16'h0, 2'b11); bBe = 2'b10;
    regWr = 1; regSel = '0; regWdata = 16'h0001;
    step(); noteMis(); regWr = 0;
    rd(0, rv); check("R9 new wins", int'(rv), stat(8));
    check("R9 irq stays", int'(irqA & irqB), 1);
    clearFault();

    // R10: saturation; clear does not reset count
    rd(1, rv); check("R10 count so far", int'(rv), expCnt);
    for (int i = 0; i < 20; i++) begin
      setIdle(); bothBus(0, 8'h00, 16'h0, 2'b11); aAddr = ADDR_W'(i + 1);
      step(); noteMis();
    end
    rd(1, rv); check("R10 saturated", int'(rv), CNT_MAX);
    clearFault();
    rd(1, rv); check("R10 count survives clear", int'(rv), CNT_MAX);

    // R11: injection at every bit position, single shot
    for (int i = 0; i < DATA_W; i++) begin
      setIdle(); injArm = 1; injBit = IDX_W'(i);
      step();
      setIdle(); bothBus(0, 8'h30, 16'h0F0F, 2'b11);
      step();
      rd(0, rv); check($sformatf("R11 bit %0d read not used", i), int'(rv), 0);
      setIdle(); bothBus(1, 8'h30, 16'h0F0F, 2'b11);
      step();
      rd(0, rv); check($sformatf("R11 bit %0d fired", i), int'(rv), stat(2));
      clearFault();
      setIdle(); bothBus(1, 8'h30, 16'h0F0F, 2'b11);
      step();
      rd(0, rv); check($sformatf("R11 bit %0d once", i), int'(rv), 0);
    end

    // R12: injection cancels a difference at the same bit
    for (int i = 0; i < DATA_W; i++) begin
      setIdle(); injArm = 1; injBit = IDX_W'(i);
      step();
      setIdle(); bothBus(1, 8'h31, 16'h3C3C, 2'b11); aWdata = 16'h3C3C ^ DATA_W'(1 << i);
      step();
      rd(0, rv); check($sformatf("R12 bit %0d cancelled", i), int'(rv), 0);
      step();
      rd(0, rv); check($sformatf("R12 bit %0d spent", i), int'(rv), stat(2));
      clearFault();
    end

    summary();
  end
endmodule